// File: doc/BRIEF.md
# Two-Level Logic Array with Built-In Product-Line Selection Code

This block is a combinational sum-of-products array. The first plane forms product terms from a set of primary inputs. The second plane ORs selected product terms onto the outputs. Both planes are fixed at elaboration time by packed parameters.

The product-term plane has a second group of columns driven by dedicated test inputs. Each product line gets a code in those columns that depends only on its position in the array, never on the programmed function. The low bits of the code give the line's position in binary. One more bit makes the whole code even parity. Because of the parity bit, any two lines differ in at least two code bits. In test mode, applying one line's code therefore enables that line alone. A pattern one bit away from a valid code enables no line at all.

When the test enable is low, every code literal is held at its non-blocking value. The array then computes exactly the programmed function, whatever sits on the test inputs.

Top module: `dp_pla`

## Requirements
- R1: With `test_en` low, every output equals the OR over its connected product lines of the programmed product terms, and the value on `tst_code` has no effect on any output.
- R2: The product plane personality holds two bits per (line i, input j) entry at bit offset 2*(i*N_IN+j). Bit 0 set means the input takes part in the term. Bit 1 picks the polarity: 1 for the true literal, 0 for the complement. An entry with bit 0 clear is a don't-care.
- R3: The output plane personality holds one bit per (output o, line i) at offset o*N_PROD+i. A 1 connects the line to the output, and a 0 leaves it unconnected. An output with no active connected line is 0.
- R4: With `test_en` high, product line i is enabled only when `tst_code[IDX_W-1:0]` equals i in binary and `tst_code[IDX_W]` equals the XOR of the bits of i. Here IDX_W = ceil(log2 N_PROD). An enabled line still needs its programmed literals to be true before it drives the outputs.
- R5: With `test_en` high, a test code that is a single bit flip away from a valid line code enables no product line. The same holds for any pattern of odd overall parity.
- R6: With `test_en` high, an index field of N_PROD or more enables no product line, so all outputs are 0.
- R7: The outputs are purely combinational. They settle in the same cycle as the input change, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_in | input | N_IN | Primary inputs to the product plane |
| tst_code | input | IDX_W+1 | Test-column inputs: line index field plus parity bit |
| test_en | input | 1 | High enables the test-column literals |
| y_out | output | N_OUT | Sum-of-products outputs |

## Verification
Every output of this block is due in the cycle its inputs are applied, because no register sits on the path. The driver changes the inputs on the falling clock edge and queues the expected word. The monitor pops that word on the following rising edge, half a period later, and compares it there. This places each comparison in the cycle its stimulus is applied.

The normal-mode sweep pairs every primary pattern with several test-code values. This shows the test columns have no effect when `test_en` is low. The test-mode sweep covers every test-code value, which includes valid codes, single-bit neighbours and out-of-range indices. A closing run changes the inputs on every cycle to confirm same-cycle settling.

// File: rtl/dp_pkg.sv
package dp_pkg;

    // One product-plane personality entry.
    typedef struct packed {
        logic pol;   // 1: true literal, 0: complement literal
        logic used;  // 1: input takes part in the term
    } and_ent_t;

    // XOR of the low kbits of idx.
    function automatic logic idx_parity(int unsigned idx, int unsigned kbits);
        logic p;
        p = 1'b0;
        for (int unsigned b = 0; b < kbits; b++) begin
            p = p ^ idx[b];
        end
        return p;
    endfunction

    // Full selection code of a line: index in the low kbits, parity on top.
    function automatic int unsigned line_code(int unsigned idx, int unsigned kbits);
        int unsigned c;
        c = idx & ((32'd1 << kbits) - 32'd1);
        if (idx_parity(idx, kbits)) begin
            c = c | (32'd1 << kbits);
        end
        return c;
    endfunction

endpackage

// File: rtl/dp_code_match.sv
module dp_code_match #(
    parameter int N_PROD = 6,
    localparam int IDX_W = $clog2(N_PROD),
    localparam int CODE_W = IDX_W + 1
) (
    input  logic              test_en,
    input  logic [CODE_W-1:0] tst_code,
    output logic [N_PROD-1:0] line_en
);

    for (genvar i = 0; i < N_PROD; i++) begin : g_line
        localparam logic [CODE_W-1:0] CODE =
            CODE_W'(dp_pkg::line_code(i, IDX_W));
        logic [CODE_W-1:0] lit;
        for (genvar b = 0; b < CODE_W; b++) begin : g_bit
            // Literal is forced to its passing value when test columns are off.
            if (CODE[b]) begin : g_true
                assign lit[b] = tst_code[b] | ~test_en;
            end else begin : g_comp
                assign lit[b] = ~tst_code[b] | ~test_en;
            end
        end
        assign line_en[i] = &lit;
    end

    // Checks next to the selector.
    always_comb begin
        int unsigned idx;
        idx = 0;
        for (int b = 0; b < IDX_W; b++) begin
            idx = idx | (int'(tst_code[b]) << b);
        end
        if (!$isunknown({test_en, tst_code})) begin
            // R1: test columns disabled -> every line passes its code literals
            a_r1_neutral_code: assert (test_en || (&line_en))
                else $error("code literals not neutral in normal mode");
            // R4: at most one line can be enabled by a test code
            a_r4_single_line: assert (!test_en || $onehot0(line_en))
                else $error("more than one line enabled by a test code");
            // R5: any enabled line implies an even-parity code word
            a_r5_even_parity: assert (!test_en || !(|line_en) || !(^tst_code))
                else $error("odd-parity code enabled a line");
            // R6: out-of-range index enables nothing
            a_r6_out_of_range: assert (!test_en || idx < N_PROD || line_en == '0)
                else $error("out-of-range index enabled a line");
        end
    end

endmodule

// File: rtl/dp_and_plane.sv
module dp_and_plane #(
    parameter int N_IN = 4,
    parameter int N_PROD = 6,
    parameter logic [2*N_IN*N_PROD-1:0] AND_PERS = '0
) (
    input  logic [N_IN-1:0]   x_in,
    input  logic [N_PROD-1:0] line_en,
    output logic [N_PROD-1:0] prod
);

    for (genvar i = 0; i < N_PROD; i++) begin : g_prod
        logic [N_IN-1:0] lit;
        for (genvar j = 0; j < N_IN; j++) begin : g_in
            localparam dp_pkg::and_ent_t ENT =
                dp_pkg::and_ent_t'(AND_PERS[2*(i*N_IN+j) +: 2]);
            if (!ENT.used) begin : g_dc
                assign lit[j] = 1'b1;
            end else if (ENT.pol) begin : g_true
                assign lit[j] = x_in[j];
            end else begin : g_comp
                assign lit[j] = ~x_in[j];
            end
        end
        assign prod[i] = (&lit) & line_en[i];
    end

    always_comb begin
        if (!$isunknown({x_in, line_en})) begin
            // R4: a line whose code did not match never drives a product
            a_r4_gated_by_code: assert ((prod & ~line_en) == '0)
                else $error("product active without code match");
        end
    end

endmodule

// File: rtl/dp_or_plane.sv
module dp_or_plane #(
    parameter int N_PROD = 6,
    parameter int N_OUT = 3,
    parameter logic [N_OUT*N_PROD-1:0] OR_PERS = '0
) (
    input  logic [N_PROD-1:0] prod,
    output logic [N_OUT-1:0]  y_out
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        localparam logic [N_PROD-1:0] CONN = OR_PERS[o*N_PROD +: N_PROD];
        assign y_out[o] = |(prod & CONN);
    end

    always_comb begin
        if (!$isunknown(prod)) begin
            // R3: no active product line -> all outputs low
            a_r3_idle_outputs_low: assert (prod != '0 || y_out == '0)
                else $error("output high with no active product");
        end
    end

endmodule

// File: rtl/dp_pla.sv
module dp_pla #(
    parameter int N_IN = 4,
    parameter int N_PROD = 6,
    parameter int N_OUT = 3,
    parameter logic [2*N_IN*N_PROD-1:0] AND_PERS = 48'h3AC5_0F93_6E21,
    parameter logic [N_OUT*N_PROD-1:0] OR_PERS = 18'h2D5A3,
    localparam int IDX_W = $clog2(N_PROD),
    localparam int CODE_W = IDX_W + 1
) (
    input  logic [N_IN-1:0]   x_in,
    input  logic [CODE_W-1:0] tst_code,
    input  logic              test_en,
    output logic [N_OUT-1:0]  y_out
);

    logic [N_PROD-1:0] line_en;
    logic [N_PROD-1:0] prod;

    dp_code_match #(.N_PROD(N_PROD)) i_code (
        .test_en (test_en),
        .tst_code(tst_code),
        .line_en (line_en)
    );

    dp_and_plane #(.N_IN(N_IN), .N_PROD(N_PROD), .AND_PERS(AND_PERS)) i_and (
        .x_in   (x_in),
        .line_en(line_en),
        .prod   (prod)
    );

    dp_or_plane #(.N_PROD(N_PROD), .N_OUT(N_OUT), .OR_PERS(OR_PERS)) i_or (
        .prod (prod),
        .y_out(y_out)
    );

endmodule

// File: tb/test_dp_pla.sv
module test_dp_pla;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam int M = 6;
    localparam int L = 3;
    localparam int K = $clog2(M);
    localparam int CW = K + 1;
    localparam logic [2*N*M-1:0] AND_P = 48'h3AC5_0F93_6E21;
    localparam logic [L*M-1:0] OR_P = 18'h2D5A3;

    typedef struct {
        logic [L-1:0] exp;
        string tag;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] x_in = '0;
    logic [CW-1:0] tst_code = '0;
    logic test_en = 1'b0;
    logic [L-1:0] y_out;
    item_t sb[$];
    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dp_pla #(.N_IN(N), .N_PROD(M), .N_OUT(L), .AND_PERS(AND_P), .OR_PERS(OR_P)) i_dp_pla (
        .x_in(x_in), .tst_code(tst_code), .test_en(test_en), .y_out(y_out)
    );

    // Reference from R2/R3/R4 encodings.
    function automatic logic [L-1:0] ref_out(logic [N-1:0] x, logic [CW-1:0] e, logic te);
        logic [M-1:0] p;
        logic [L-1:0] r;
        for (int i = 0; i < M; i++) begin
            logic on;
            logic par;
            on = 1'b1;
            par = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (AND_P[2*(i*N+j)] && (x[j] != AND_P[2*(i*N+j)+1])) on = 1'b0;
            end
            for (int b = 0; b < K; b++) par = par ^ i[b];
            if (te && ((int'(e[K-1:0]) != i) || (e[K] != par))) on = 1'b0;
            p[i] = on;
        end
        for (int o = 0; o < L; o++) r[o] = |(p & OR_P[o*M +: M]);
        return r;
    endfunction

    task automatic drive(logic [N-1:0] x, logic [CW-1:0] e, logic te, string tag);
        item_t it;
        @(negedge clk);
        x_in = x;
        tst_code = e;
        test_en = te;
        it.exp = ref_out(x, e, te);
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: result due in the same cycle, compared half a period later.
    always @(posedge clk) begin
        if (!rst && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_vec++;
            if (y_out !== it.exp) begin
                n_bad++;
                $display("FAIL %s: x=%h code=%h te=%b got %b expected %b",
                         it.tag, x_in, tst_code, test_en, y_out, it.exp);
            end
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // Quiescent state: all inputs low, normal mode (R1)
        drive('0, '0, 1'b0, "R1 idle");
        // Normal mode: extra columns must have no effect (R1 R2 R3)
        for (int x = 0; x < (1 << N); x++) begin
            drive(N'(x), CW'(0), 1'b0, "R1 R2 normal");
            drive(N'(x), CW'(5), 1'b0, "R1 ignore code");
            drive(N'(x), '1, 1'b0, "R3 ignore code");
            drive(N'(x), CW'(dp_pkg::line_code(3, K)), 1'b0, "R1 valid code ignored");
        end
        // Test mode: every code against every primary pattern (R4 R5 R6)
        for (int x = 0; x < (1 << N); x++) begin
            for (int e = 0; e < (1 << CW); e++) begin
                if ((e % (1 << K)) >= M) drive(N'(x), CW'(e), 1'b1, "R6 out of range");
                else if (^(CW'(e))) drive(N'(x), CW'(e), 1'b1, "R5 odd parity");
                else drive(N'(x), CW'(e), 1'b1, "R4 valid code");
            end
        end
        // Single-bit neighbours of each valid code (R5)
        for (int i = 0; i < M; i++) begin
            for (int b = 0; b < CW; b++) begin
                drive('1, CW'(dp_pkg::line_code(i, K)) ^ (CW'(1) << b), 1'b1, "R5 neighbour");
            end
        end
        // Inputs toggling every cycle (R7)
        for (int c = 0; c < 24; c++) begin
            drive(N'(c * 7), CW'(c), 1'(c % 2), "R7 same cycle");
        end
        @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule